// File: doc/BRIEF.md
# Scrambled NRZI Serializer

This block turns a stream of 10-bit parallel words into a single serial line for a coaxial-style link. It runs on the bit-rate clock. An internal phase counter picks out every tenth cycle as the word slot. In that cycle the block samples the parallel word and reports the slot on a strobe output, so upstream logic knows when to present the next word. The word leaves one bit per cycle, least significant bit first. The next word follows straight after, with no gap.

Each serial bit first goes through a self-synchronizing scrambler built on x^9 + x^4 + 1. The receiver can recover clock timing from the scrambled stream without a framing agreement. The scrambled bit then goes through an x + 1 differential (NRZI) encoder, so the cable polarity does not matter. The line is a complementary pair with a registered output stage. When the lock input is low, the pair is held at a fixed idle level, while the scrambler and encoder keep running underneath.

Top module: `sernrzi_tx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, ser_p is 1 and ser_n is 0. word_load is 1 in the first cycle after reset is released.
- R2: word_load is high for exactly one cycle in every ten. The parallel word is sampled on each rising edge where word_load is high.
- R3: Bits leave least significant bit first. Bit j (0..9) of the word sampled at edge L is the scrambler input for edge L+1+j.
- R4: The scrambled bit is s(t) = d(t) XOR s(t-4) XOR s(t-9). The scrambler history is zero after reset.
- R5: The NRZI state toggles exactly when the scrambled bit is 1. It is zero after reset.
- R6: ser_n is always the complement of ser_p.
- R7: If lock is low at a rising edge, ser_p is 1 and ser_n is 0 after that edge. If lock is high, ser_p takes the NRZI state held before that edge.
- R8: The scrambler and NRZI state keep advancing while lock is low. After relock, the output equals what an uninterrupted stream would give.
- R9: Bit n of the serial stream (word n/10, bit n mod 10) appears on ser_p after rising edge n+2, counted from the first edge after reset release as edge 0.
- R10: After at least eleven consecutive locked samples, XOR-differencing ser_p and descrambling with the same polynomial recovers the original words bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 10 | Parallel word, sampled when word_load is high |
| lock | input | 1 | Clock-lock indication; low forces the idle line state |
| word_load | output | 1 | High in the cycle whose rising edge samples word_in |
| ser_p | output | 1 | Serial line, true side |
| ser_n | output | 1 | Serial line, complement side |

## Verification
The hardest case to reach from the ports is a relock. The scrambler and NRZI state are hidden while lock is low, so the first bits after relock can only be right if both kept advancing during the idle window. The stimulus drops lock for a long window in the middle of random traffic, and for a single cycle later on. A forward model predicts every line bit across these gaps. A separate differential decoder and descrambler checks that the words are recovered once lock has been stable for long enough. Directed words with all zeros, all ones, alternating bits and single set bits expose bit-order and tap errors.

// File: rtl/sertx_pkg.sv
// Package: shared constants for the scrambled NRZI serializer.
// Assumes all users take their defaults from here.
package sertx_pkg;
    localparam int unsigned WORD_W_DEF = 10;  // bits per parallel word
    localparam int unsigned TAP_A_DEF  = 4;   // near scrambler tap (x^4)
    localparam int unsigned TAP_B_DEF  = 9;   // far scrambler tap (x^9)
    localparam logic        IDLE_P     = 1'b1; // true-side level when unlocked
endpackage

// File: rtl/sertx_phase.sv
// Module: sertx_phase
// Counts bit cycles modulo WORD_W and flags the word slot (count zero).
// Assumes WORD_W >= 2. The counter restarts at zero on reset, so the first
// cycle after reset is a word slot.
module sertx_phase #(
    parameter int unsigned WORD_W = sertx_pkg::WORD_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic load
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;

    // advance the bit counter, wrapping after the last bit of a word
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign load = (cnt == '0);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < WORD_W);
    p_single_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/sertx_piso.sv
// Module: sertx_piso
// Parallel-in serial-out register. It captures a word when load is high and
// otherwise shifts right, so bit 0 leaves first.
// Assumes load comes from sertx_phase.
module sertx_piso #(
    parameter int unsigned WORD_W = sertx_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);
    logic [WORD_W-1:0] sr;

    // capture a new word in its slot, otherwise shift toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= word;
        else
            sr <= {1'b0, sr[WORD_W-1:1]};
    end

    assign bit_out = sr[0];

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load)) |-> (sr == $past(word)));
    p_lsb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> (sr[WORD_W-2:0] == $past(sr[WORD_W-1:1])));
endmodule

// File: rtl/sertx_scrambler.sv
// Module: sertx_scrambler
// Self-synchronizing scrambler: s(t) = d(t) ^ s(t-TAP_A) ^ s(t-TAP_B).
// The history register holds past scrambled bits, index 0 newest.
// It advances every cycle whatever the line state.
module sertx_scrambler #(
    parameter int unsigned TAP_A = sertx_pkg::TAP_A_DEF,
    parameter int unsigned TAP_B = sertx_pkg::TAP_B_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sbit
);
    logic [TAP_B-1:0] hist;

    assign sbit = din ^ hist[TAP_A-1] ^ hist[TAP_B-1];

    // push the newest scrambled bit into the history
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= {hist[TAP_B-2:0], sbit};
    end

    p_history_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hist[TAP_B-1:1] == $past(hist[TAP_B-2:0])));
endmodule

// File: rtl/sertx_nrzi_out.sv
// Module: sertx_nrzi_out
// NRZI encoder (x + 1) followed by a registered, lock-gated complementary pair.
// Assumes lock is synchronous to clk. Gating acts on the pair only.
module sertx_nrzi_out (
    input  logic clk,
    input  logic rst_n,
    input  logic sbit,
    input  logic lock,
    output logic ser_p,
    output logic ser_n
);
    logic state;

    // toggle the line state on every scrambled one
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= 1'b0;
        else
            state <= state ^ sbit;
    end

    // drive the pair from the line state, or idle when unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_p <= sertx_pkg::IDLE_P;
            ser_n <= ~sertx_pkg::IDLE_P;
        end else if (lock) begin
            ser_p <= state;
            ser_n <= ~state;
        end else begin
            ser_p <= sertx_pkg::IDLE_P;
            ser_n <= ~sertx_pkg::IDLE_P;
        end
    end

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((state ^ $past(state)) == $past(sbit)));
    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_p != ser_n);
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> (ser_p && !ser_n));
endmodule

// File: rtl/sernrzi_tx.sv
// Module: sernrzi_tx
// Top of the scrambled NRZI serializer. The clock runs at the bit rate.
// One word is taken every WORD_W cycles; word_load marks the slot.
module sernrzi_tx #(
    parameter int unsigned WORD_W = sertx_pkg::WORD_W_DEF,
    parameter int unsigned TAP_A  = sertx_pkg::TAP_A_DEF,
    parameter int unsigned TAP_B  = sertx_pkg::TAP_B_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              lock,
    output logic              word_load,
    output logic              ser_p,
    output logic              ser_n
);
    logic nrz_bit;
    logic scr_bit;

    sertx_phase #(.WORD_W(WORD_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(word_load)
    );

    sertx_piso #(.WORD_W(WORD_W)) u_piso (
        .clk(clk), .rst_n(rst_n), .load(word_load), .word(word_in), .bit_out(nrz_bit)
    );

    sertx_scrambler #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_scr (
        .clk(clk), .rst_n(rst_n), .din(nrz_bit), .sbit(scr_bit)
    );

    sertx_nrzi_out u_out (
        .clk(clk), .rst_n(rst_n), .sbit(scr_bit), .lock(lock), .ser_p(ser_p), .ser_n(ser_n)
    );
endmodule

// File: tb/sernrzi_tx_test.sv
// Bench for sernrzi_tx. A forward model predicts the line bit by bit.
// A separate descrambler checks that the words are recovered.
module sernrzi_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       lock = 1'b0;
    logic       word_load;
    logic       ser_p;
    logic       ser_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit stream [0:4095];
    int nwords = 0;

    logic [8:0] mh = '0;    // model scrambler history, [0] newest
    logic       mstate = 1'b0;
    logic [8:0] dh = '0;    // descrambler history
    logic       prev_p = 1'b1;
    int         streak = 0;
    bit         relocked = 0;

    sernrzi_tx uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .lock(lock),
        .word_load(word_load), .ser_p(ser_p), .ser_n(ser_n)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] pick_word(input int idx);
        case (idx)
            0: return 10'h000;  1: return 10'h3FF;  2: return 10'h000;
            3: return 10'h000;  4: return 10'h001;  5: return 10'h200;
            6: return 10'h155;  7: return 10'h2AA;  8: return 10'h3FF;
            9: return 10'h3FF;  10: return 10'h000; 11: return 10'h010;
            default: return 10'($urandom & 32'h3FF);
        endcase
    endfunction

    function automatic bit lock_plan(input int cyc);
        if (cyc < 5) return 1'b0;
        if (cyc >= 600 && cyc < 637) return 1'b0;
        if (cyc == 900) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        logic  exp_p;
        logic  s;
        logic  nrz;
        logic  rec;
        bit    lk;
        string tag;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ser_p == 1'b1 && ser_n == 1'b0, "R1 reset pair", int'({ser_p, ser_n}), 2);
        check(word_load == 1'b1, "R1 slot at reset", int'(word_load), 1);
        word_in = pick_word(nwords);
        for (int j = 0; j < 10; j++) stream[nwords*10 + j] = word_in[j];
        nwords++;
        rst_n = 1'b1;
        lock = lock_plan(0);
        for (int m = 0; m < 2400; m++) begin
            @(posedge clk);
            @(negedge clk);
            lk = lock;
            // line prediction: R3 R4 R5 R9 while locked, R7 idle, R8 after relock
            exp_p = lk ? mstate : 1'b1;
            if (m == 0) tag = "R1 first cycle";
            else if (!lk) tag = "R7 idle";
            else if (relocked) tag = "R8 relock";
            else tag = "R3 R4 R5 R9 line bit";
            check(ser_p == exp_p, tag, int'(ser_p), int'(exp_p));
            check(ser_n == ~ser_p, "R6 complement", int'(ser_n), int'(~ser_p));
            check(word_load == ((m + 1) % 10 == 0), "R2 slot period", int'(word_load),
                  int'((m + 1) % 10 == 0));
            // independent recovery: R10
            streak = lk ? streak + 1 : 0;
            nrz = ser_p ^ prev_p;
            rec = nrz ^ dh[3] ^ dh[8];
            dh = {dh[7:0], nrz};
            prev_p = ser_p;
            if (streak >= 11 && m >= 2)
                check(rec == stream[m-2], "R10 recovered bit", int'(rec), int'(stream[m-2]));
            if (!lk) relocked = 1;
            else if (streak > 20) relocked = 0;
            // model: bit m-1 enters scrambler and NRZI at this edge
            if (m >= 1) begin
                s = stream[m-1] ^ mh[3] ^ mh[8];
                mh = {mh[7:0], s};
                mstate = mstate ^ s;
            end
            lock = lock_plan(m + 1);
            if (word_load) begin
                word_in = pick_word(nwords);
                for (int j = 0; j < 10; j++) stream[nwords*10 + j] = word_in[j];
                nwords++;
            end
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule